// File: doc/BRIEF.md
# Receive Descriptor Ring Buffer Writer

This block sits between a MAC receive path and system memory. Frames arrive as a stream of 32-bit words. The block places them into fixed 128-byte buffers. Each buffer is described by a two-word descriptor in a ring in memory. For every buffer it reads the descriptor's address word and checks that the buffer is free. It then writes the payload words and hands the buffer back with a status word. The status word records where the frame starts and ends, the frame length, and the address-match results that the receive filter supplies alongside the last word.

A frame longer than one buffer continues in the next descriptor. The ring is walked in steps of eight bytes until a descriptor carrying the wrap flag sends the walk back to the ring base. Software frees a buffer by clearing its used bit. If the engine meets a descriptor that is still in use, it discards the rest of the frame and pulses a buffer-shortage output. While reception is disabled, incoming frames are discarded silently and the walk restarts at the ring base.

Top module: `rxdma_writer`

## Requirements
- R1: After reset, `mem_req`, `in_ready` and `nobuf` are low, and the first frame after enabling reception uses the descriptor at `ring_base`.
- R2: Descriptor i sits at `ring_base + 8*i`. Its word at offset 0 holds the buffer address in bits 31:2, the used bit in bit 0 and the wrap flag in bit 1. Its word at offset 4 is the status word.
- R3: Payload word k of a buffer is written to buffer address `+ 4*k`. A buffer takes at most 32 words (128 bytes), and a longer frame continues in the next descriptor's buffer.
- R4: In the status word, bit 14 is set only in a frame's first buffer and bit 15 only in its last. Bits 11:0 hold the frame length in bytes on the last buffer and zero elsewhere. The length is 4 per word, except the last word, which contributes `in_nbytes + 1` (`in_nbytes` = 0..3).
- R5: On the last buffer only, status bit 31 carries `in_bcast`, bits 26, 25, 24 and 23 carry `in_sa_hit[0]` to `in_sa_hit[3]`, and bit 22 carries `in_type_hit`, all sampled with the last word. These bits are zero on other buffers.
- R6: For each filled buffer the status word is written before the address word. The address word is written back with bits 31:1 unchanged and bit 0 set.
- R7: After a descriptor whose wrap flag is set, the next descriptor is the one at `ring_base`; otherwise it is the one 8 bytes further on.
- R8: If the descriptor fetched for a new frame is already used, the whole frame is consumed without any memory write, `nobuf` pulses for one cycle, and the next frame uses that same descriptor.
- R9: If a descriptor fetched in the middle of a frame is already used, the rest of the frame is consumed without memory writes and `nobuf` pulses. Buffers already filled keep their writeback (first flag set, last flag clear), and the next frame uses the busy descriptor.
- R10: While `rx_en` is low and no frame is in progress, frames are consumed without memory writes or `nobuf`, and the walk position reloads from `ring_base`.
- R11: A memory request keeps its address and direction until `mem_ack`. An input word is accepted only in the cycle its memory write is acknowledged, so memory stalls hold back the input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enable |
| ring_base | input | 32 | Byte address of descriptor 0 |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| in_data | input | 32 | Input payload word |
| in_last | input | 1 | Last word of the frame |
| in_nbytes | input | 2 | Valid bytes minus one in the last word |
| in_bcast | input | 1 | Broadcast flag, valid with the last word |
| in_sa_hit | input | 4 | Specific-address matches 1..4 (bit 0 = first), valid with the last word |
| in_type_hit | input | 1 | Type-ID match, valid with the last word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completes in this cycle |
| nobuf | output | 1 | One-cycle pulse: used descriptor met, frame data dropped |

## Verification
The hardest case to reach is a descriptor that turns out to be in use after part of a frame has already been stored. The bench gets there by re-arming the ring, marking only the descriptor after the current one as used, and sending a frame longer than one buffer. It then checks both the partial writeback and the position where the next frame lands. Ring wrap is reached without extra effort: a sweep of frame lengths around the 128-byte boundaries runs across a four-entry ring, once with an always-ready memory and once with a memory that stalls every fourth cycle.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DATA,
        ST_WSTAT,
        ST_WADDR,
        ST_DROP
    } rx_state_t;

    // descriptor word layout (fixed by the memory format software reads)
    localparam int DESC_BYTES = 8;
    localparam int USED_POS   = 0;
    localparam int WRAP_POS   = 1;
    localparam int LEN_W      = 12;
    localparam int FIRST_POS  = 14;
    localparam int LAST_POS   = 15;
    localparam int TYPE_POS   = 22;
    localparam int SA4_POS    = 23;   // match 1 lands highest, at SA4_POS+3
    localparam int BCAST_POS  = 31;

    typedef struct packed {
        logic       bcast;
        logic [3:0] sa_hit;
        logic       type_hit;
    } rx_flags_t;

    function automatic logic [31:0] make_status(logic first, logic last,
                                                logic [LEN_W-1:0] len,
                                                rx_flags_t fl);
        logic [31:0] w;
        w = '0;
        w[FIRST_POS] = first;
        w[LAST_POS]  = last;
        if (last) begin
            w[LEN_W-1:0]  = len;
            w[BCAST_POS]  = fl.bcast;
            w[TYPE_POS]   = fl.type_hit;
            for (int i = 0; i < 4; i++)
                w[SA4_POS + 3 - i] = fl.sa_hit[i];
        end
        return w;
    endfunction

endpackage

// File: rtl/rxdma_ring_ptr.sv
module rxdma_ring_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reload,
    input  logic          adv,
    input  logic          wrap,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] ptr
);
    import rxdma_pkg::*;

    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    always_ff @(posedge clk) begin
        if (rst || reload)
            ptr <= base;
        else if (adv)
            ptr <= wrap ? base : ptr + STEP;
    end

endmodule

// File: rtl/rxdma_fill_ctr.sv
module rxdma_fill_ctr #(
    parameter int BUF_BYTES = 128,
    parameter int LW        = 12,
    parameter int WCNT_W    = $clog2(BUF_BYTES / 4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_frame,
    input  logic              clr_buf,
    input  logic              beat,
    input  logic              last,
    input  logic [1:0]        nbytes,
    output logic [WCNT_W-1:0] wcnt,
    output logic              buf_full,
    output logic [LW-1:0]     len
);
    localparam int WORDS = BUF_BYTES / 4;
    localparam logic [WCNT_W-1:0] WMAX = WCNT_W'(WORDS - 1);

    logic [LW-1:0] step;

    always_comb begin
        if (last)
            step = LW'(nbytes) + LW'(1);
        else
            step = LW'(4);
    end

    assign buf_full = (wcnt == WMAX);

    always_ff @(posedge clk) begin
        if (rst || clr_buf)
            wcnt <= '0;
        else if (beat)
            wcnt <= wcnt + WCNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_frame)
            len <= '0;
        else if (beat)
            len <= len + step;
    end

endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
    import rxdma_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_en,
    input  logic      in_valid,
    input  logic      in_last,
    input  logic      mem_ack,
    input  logic      desc_used,
    input  logic      buf_full,
    output rx_state_t st,
    output logic      in_ready,
    output logic      mem_req,
    output logic      mem_we,
    output logic      beat,
    output logic      frame_begin,
    output logic      desc_take,
    output logic      wb_done,
    output logic      first_buf,
    output logic      last_buf,
    output logic      nobuf
);
    rx_state_t st_n;
    logic      nobuf_n;

    assign beat        = (st == ST_DATA) && in_valid && mem_ack;
    assign frame_begin = (st == ST_IDLE) && in_valid && rx_en;
    assign desc_take   = (st == ST_FETCH) && mem_ack && !desc_used;
    assign wb_done     = (st == ST_WADDR) && mem_ack;

    assign in_ready = ((st == ST_DATA) && mem_ack) || (st == ST_DROP);
    assign mem_req  = (st == ST_FETCH) || (st == ST_WSTAT) || (st == ST_WADDR)
                   || ((st == ST_DATA) && in_valid);
    assign mem_we   = (st != ST_FETCH);

    always_comb begin
        st_n    = st;
        nobuf_n = 1'b0;
        unique case (st)
            ST_IDLE:
                if (in_valid) st_n = rx_en ? ST_FETCH : ST_DROP;
            ST_FETCH:
                if (mem_ack) begin
                    if (desc_used) begin
                        st_n    = ST_DROP;
                        nobuf_n = 1'b1;
                    end else begin
                        st_n = ST_DATA;
                    end
                end
            ST_DATA:
                if (beat && (in_last || buf_full)) st_n = ST_WSTAT;
            ST_WSTAT:
                if (mem_ack) st_n = ST_WADDR;
            ST_WADDR:
                if (mem_ack) st_n = last_buf ? ST_IDLE : ST_FETCH;
            ST_DROP:
                if (in_valid && in_last) st_n = ST_IDLE;
            default:
                st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            nobuf <= 1'b0;
        end else begin
            st    <= st_n;
            nobuf <= nobuf_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            first_buf <= 1'b0;
        else if (frame_begin)
            first_buf <= 1'b1;
        else if (wb_done)
            first_buf <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            last_buf <= 1'b0;
        else if (beat && in_last)
            last_buf <= 1'b1;
        else if (wb_done)
            last_buf <= 1'b0;
    end

    // R8
    nobuf_drop_chk: assert property (@(posedge clk) disable iff (rst)
        nobuf |-> (st == ST_DROP));

    // R8
    nobuf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        nobuf |=> !nobuf);

    // R6
    wb_order_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_WADDR) && ($past(st) != ST_WADDR)) |-> ($past(st) == ST_WSTAT));

endmodule

// File: rtl/rxdma_writer.sv
module rxdma_writer #(
    parameter int AW        = 32,
    parameter int BUF_BYTES = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_en,
    input  logic [AW-1:0] ring_base,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [31:0]   in_data,
    input  logic          in_last,
    input  logic [1:0]    in_nbytes,
    input  logic          in_bcast,
    input  logic [3:0]    in_sa_hit,
    input  logic          in_type_hit,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    output logic          nobuf
);
    import rxdma_pkg::*;

    localparam int WCNT_W = $clog2(BUF_BYTES / 4);

    rx_state_t         st;
    logic              beat, frame_begin, desc_take, wb_done;
    logic              first_buf, last_buf, buf_full;
    logic [WCNT_W-1:0] wcnt;
    logic [LEN_W-1:0]  flen;
    logic [AW-1:0]     ptr;
    logic [AW-1:0]     buf_q;
    logic              wrap_q;
    rx_flags_t         flags_q;

    rxdma_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .rx_en       (rx_en),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .mem_ack     (mem_ack),
        .desc_used   (mem_rdata[USED_POS]),
        .buf_full    (buf_full),
        .st          (st),
        .in_ready    (in_ready),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .beat        (beat),
        .frame_begin (frame_begin),
        .desc_take   (desc_take),
        .wb_done     (wb_done),
        .first_buf   (first_buf),
        .last_buf    (last_buf),
        .nobuf       (nobuf)
    );

    rxdma_fill_ctr #(
        .BUF_BYTES (BUF_BYTES),
        .LW        (LEN_W),
        .WCNT_W    (WCNT_W)
    ) u_fill (
        .clk       (clk),
        .rst       (rst),
        .clr_frame (frame_begin),
        .clr_buf   (desc_take),
        .beat      (beat),
        .last      (in_last),
        .nbytes    (in_nbytes),
        .wcnt      (wcnt),
        .buf_full  (buf_full),
        .len       (flen)
    );

    rxdma_ring_ptr #(
        .AW (AW)
    ) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .reload ((st == ST_IDLE) && !rx_en),
        .adv    (wb_done),
        .wrap   (wrap_q),
        .base   (ring_base),
        .ptr    (ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            wrap_q <= 1'b0;
        end else if (desc_take) begin
            buf_q  <= {mem_rdata[AW-1:2], 2'b00};
            wrap_q <= mem_rdata[WRAP_POS];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (beat && in_last)
            flags_q <= '{bcast: in_bcast, sa_hit: in_sa_hit, type_hit: in_type_hit};
    end

    always_comb begin
        mem_addr  = ptr;
        mem_wdata = '0;
        unique case (st)
            ST_DATA: begin
                mem_addr  = buf_q + AW'({wcnt, 2'b00});
                mem_wdata = in_data;
            end
            ST_WSTAT: begin
                mem_addr  = ptr + AW'(4);
                mem_wdata = make_status(first_buf, last_buf, flen, flags_q);
            end
            ST_WADDR: begin
                mem_addr  = ptr;
                mem_wdata = {buf_q[31:2], wrap_q, 1'b1};
            end
            default: begin
                mem_addr  = ptr;
                mem_wdata = '0;
            end
        endcase
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && (st != ST_DATA || in_valid)) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11
    accept_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && (st != ST_DROP)) |-> (mem_req && mem_we && mem_ack));

    // R3
    buf_range_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_DATA) && mem_req) |-> ((mem_addr - buf_q) < AW'(BUF_BYTES)));

    // R8
    drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DROP) |-> !mem_req);

endmodule

// File: tb/rxdma_writer_tb.sv
module rxdma_writer_tb;

    localparam logic [31:0] RB    = 32'h100;
    localparam logic [31:0] BB    = 32'h400;
    localparam int          NDESC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic [1:0]  in_nbytes = '0;
    logic        in_bcast = 1'b0;
    logic [3:0]  in_sa_hit = '0;
    logic        in_type_hit = 1'b0;
    logic        mem_req, mem_we, mem_ack, nobuf;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [0:511];
    logic        stat_seen [0:NDESC-1];
    int          ord_err = 0;
    int          wr_cnt = 0;
    int          nobuf_cnt = 0;
    logic [31:0] cyc = '0;
    logic        stall_en = 1'b0;
    int          checks = 0;
    int          fails = 0;
    int          exp_idx = 0;

    always #2 clk = ~clk;

    rxdma_writer u_dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .ring_base(RB),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_nbytes(in_nbytes), .in_bcast(in_bcast),
        .in_sa_hit(in_sa_hit), .in_type_hit(in_type_hit),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .nobuf(nobuf)
    );

    assign mem_ack   = mem_req && (!stall_en || (cyc[1:0] != 2'b01));
    assign mem_rdata = mem[mem_addr[10:2]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && nobuf) nobuf_cnt <= nobuf_cnt + 1;
    end

    always @(posedge clk) begin
        if (mem_req && mem_ack && mem_we) begin
            wr_cnt = wr_cnt + 1;
            if (mem_addr >= RB && mem_addr < RB + 8 * NDESC) begin
                if (mem_addr[2])
                    stat_seen[(mem_addr - RB) >> 3] = 1'b1;
                else if (mem_wdata[0] && !stat_seen[(mem_addr - RB) >> 3])
                    ord_err = ord_err + 1;
            end
            mem[mem_addr[10:2]] = mem_wdata;
        end
    end

    task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] w0_of(input int d);
        return (BB + 32'(128 * d)) | ((d == NDESC - 1) ? 32'h2 : 32'h0);
    endfunction

    function automatic int didx(input int d);
        return int'(RB >> 2) + 2 * d;
    endfunction

    task automatic rearm();
        for (int i = 0; i < NDESC; i++) begin
            mem[didx(i)]     = w0_of(i);
            mem[didx(i) + 1] = 32'h0;
            stat_seen[i]     = 1'b0;
        end
        for (int w = 0; w < 32 * NDESC; w++)
            mem[int'(BB >> 2) + w] = 32'hDEADBEEF;
    endtask

    function automatic logic [31:0] pat(input logic [7:0] seed, input int k);
        return {seed, 8'h5A, 16'(k)};
    endfunction

    task automatic send_frame(input int len, input logic [5:0] fl, input logic [7:0] seed);
        int nw;
        nw = (len + 3) / 4;
        for (int k = 0; k < nw; k++) begin
            @(negedge clk);
            in_valid    = 1'b1;
            in_data     = pat(seed, k);
            in_last     = (k == nw - 1);
            in_nbytes   = 2'((len - 1) % 4);
            in_bcast    = fl[5];
            in_sa_hit   = fl[4:1];
            in_type_hit = fl[0];
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_used(input int d);
        for (int i = 0; i < 400; i++) begin
            if (mem[didx(d)][0]) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_stat(input logic first, input logic last, input int len, input logic [5:0] fl);
        logic [31:0] s;
        s = '0;
        s[14] = first;
        s[15] = last;
        if (last) begin
            s[11:0] = 12'(len);
            s[31]   = fl[5];
            s[22]   = fl[0];
            for (int j = 0; j < 4; j++) s[26 - j] = fl[1 + j];
        end
        return s;
    endfunction

    // checks buffers [0, nchk) of a frame of len bytes starting at descriptor start
    task automatic check_frame(input int len, input logic [5:0] fl, input logic [7:0] seed,
                               input int start, input int nchk, input logic trunc);
        int nw, nb, d, wib, bad;
        logic [31:0] st_exp;
        nw = (len + 3) / 4;
        nb = (nw + 31) / 32;
        for (int b = 0; b < nchk; b++) begin
            d   = (start + b) % NDESC;
            wib = (nw - 32 * b > 32) ? 32 : nw - 32 * b;
            bad = 0;
            for (int w = 0; w < wib; w++)
                if (mem[int'(BB >> 2) + 32 * d + w] !== pat(seed, 32 * b + w)) bad++;
            chk(bad == 0, $sformatf("R3 R11 data len=%0d buf=%0d desc=%0d", len, b, d),
                32'(bad), 32'h0);
            st_exp = trunc ? exp_stat(b == 0, 1'b0, len, fl)
                           : exp_stat(b == 0, b == nb - 1, len, fl);
            chk(mem[didx(d) + 1] === st_exp,
                $sformatf("R4 R5 status len=%0d buf=%0d", len, b), mem[didx(d) + 1], st_exp);
            chk(mem[didx(d)] === (w0_of(d) | 32'h1),
                $sformatf("R2 R7 R6 addr word len=%0d desc=%0d", len, d), mem[didx(d)], w0_of(d) | 32'h1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lens [15] = '{1, 2, 3, 4, 5, 64, 127, 128, 129, 255, 256, 257, 300, 384, 385};
        int nb, w0, n0, start;
        logic [5:0] fl;
        for (int i = 0; i < 512; i++) mem[i] = 32'h0;
        rearm();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_req == 1'b0, "R1 mem_req in reset", 32'(mem_req), 32'h0);
        chk(in_ready == 1'b0, "R1 in_ready in reset", 32'(in_ready), 32'h0);
        chk(nobuf == 1'b0, "R1 nobuf in reset", 32'(nobuf), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_req == 1'b0, "R1 mem_req idle", 32'(mem_req), 32'h0);
        rx_en = 1'b1;
        exp_idx = 0;

        // length sweep, always-ready then stalling memory (R2..R7, R11)
        for (int mode = 0; mode < 2; mode++) begin
            stall_en = (mode == 1);
            for (int i = 0; i < 15; i++) begin
                fl = 6'(i * 11 + mode * 5);
                rearm();
                nb = ((lens[i] + 3) / 4 + 31) / 32;
                start = exp_idx;
                send_frame(lens[i], fl, 8'(i + 16 * mode));
                wait_used((start + nb - 1) % NDESC);
                check_frame(lens[i], fl, 8'(i + 16 * mode), start, nb, 1'b0);
                exp_idx = (start + nb) % NDESC;
            end
        end
        chk(ord_err == 0, "R6 status before address word", 32'(ord_err), 32'h0);
        chk(nobuf_cnt == 0, "R8 no nobuf in sweep", 32'(nobuf_cnt), 32'h0);

        // R8 used descriptor at frame start
        stall_en = 1'b0;
        rearm();
        mem[didx(exp_idx)] = w0_of(exp_idx) | 32'h1;
        w0 = wr_cnt;
        n0 = nobuf_cnt;
        send_frame(200, 6'h3F, 8'hC1);
        repeat (20) @(negedge clk);
        chk(wr_cnt == w0, "R8 no writes on drop", 32'(wr_cnt - w0), 32'h0);
        chk(nobuf_cnt == n0 + 1, "R8 nobuf pulses once", 32'(nobuf_cnt - n0), 32'h1);
        rearm();
        start = exp_idx;
        send_frame(40, 6'h01, 8'hC2);
        wait_used(start);
        check_frame(40, 6'h01, 8'hC2, start, 1, 1'b0);
        exp_idx = (start + 1) % NDESC;

        // R9 used descriptor in the middle of a frame
        rearm();
        start = exp_idx;
        mem[didx((start + 1) % NDESC)] = w0_of((start + 1) % NDESC) | 32'h1;
        n0 = nobuf_cnt;
        send_frame(300, 6'h20, 8'hD3);
        repeat (20) @(negedge clk);
        check_frame(300, 6'h20, 8'hD3, start, 1, 1'b1);
        chk(nobuf_cnt == n0 + 1, "R9 nobuf mid-frame", 32'(nobuf_cnt - n0), 32'h1);
        exp_idx = (start + 1) % NDESC;
        rearm();
        send_frame(8, 6'h10, 8'hD4);
        wait_used(exp_idx);
        check_frame(8, 6'h10, 8'hD4, exp_idx, 1, 1'b0);
        exp_idx = (exp_idx + 1) % NDESC;

        // R10 disabled reception, then restart at ring base
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
        rearm();
        w0 = wr_cnt;
        n0 = nobuf_cnt;
        send_frame(100, 6'h3F, 8'hE5);
        repeat (20) @(negedge clk);
        chk(wr_cnt == w0, "R10 no writes while disabled", 32'(wr_cnt - w0), 32'h0);
        chk(nobuf_cnt == n0, "R10 no nobuf while disabled", 32'(nobuf_cnt - n0), 32'h0);
        rx_en = 1'b1;
        send_frame(20, 6'h02, 8'hE6);
        wait_used(0);
        check_frame(20, 6'h02, 8'hE6, 0, 1, 1'b0);
        chk(ord_err == 0, "R6 final ordering", 32'(ord_err), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule